// File: doc/BRIEF.md
# ALU Hazard Detect and Stall Unit

This unit guards a five-stage in-order pipeline against read-after-write conflicts between ALU-class instructions when no operand forwarding is available. Each cycle it looks at the instruction sitting in decode (stage 2): its class flag, its two source register fields and whether its second operand is an immediate. It compares those fields against the destinations of the instructions that have already left decode and are now in stages 3, 4 and 5.

The unit keeps its own record of what occupies stages 3 to 5. This record is a short shift register fed from decode. When a conflict is seen, the unit asserts two hold outputs in the same cycle. The surrounding pipeline uses them to freeze its fetch and decode registers. At the next clock edge the unit loads a bubble into stage 3: a zero opcode with the ALU flag cleared. A bubble can never act as a producer later on.

Because of this, a consumer placed right behind its producer waits three cycles and then issues once the producer has left stage 5. This gives a producer-to-consumer spacing of four. The stage-3 opcode, class and destination are registered outputs that the next pipeline stage can use directly.

Top module: `alu_stall_unit`

## Requirements
- R1: Synchronous active-high reset empties stages 3 to 5. After reset the stage-3 outputs read opcode 0 with the ALU flag 0, and no hold is raised for any decode instruction.
- R2: When both decode and a tracked stage hold ALU-class instructions, a match between that stage's destination and the decode first source (rb) raises hold in the same cycle.
- R3: A match on the decode second source (rc) raises hold only when `dec_imm_i` is 0. With `dec_imm_i` 1, an rc-only match has no effect on hold.
- R4: The comparison covers stages 3, 4 and 5. An ALU producer that issued 2 slots earlier causes 2 stall cycles, and one that issued 3 slots earlier causes 1 stall cycle. Once the producer has passed stage 5, it causes no stall.
- R5: `hold_fetch_o` and `hold_decode_o` are always equal. Both are combinational from the current stage record and the decode inputs.
- R6: After a clock edge at which hold was high, the stage-3 outputs show a bubble: opcode 0, ALU flag 0 and destination 0. After an edge at which hold was low, they show the decode opcode, class flag and destination from before that edge.
- R7: A bubble never matches as a producer. An ALU consumer placed directly behind its ALU producer stalls for exactly 3 cycles.
- R8: A non-ALU instruction never causes a hold, whether it is in decode or in a tracked stage, whatever its register fields hold.
- R9: A destination of register 0 is compared like any other register and can cause a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_alu_i | input | 1 | Decode instruction is ALU class |
| dec_imm_i | input | 1 | Decode instruction uses an immediate instead of rc |
| dec_op_i | input | OP_W | Decode opcode |
| dec_dst_i | input | REG_W | Decode destination register (ra) |
| dec_srca_i | input | REG_W | Decode first source register (rb) |
| dec_srcb_i | input | REG_W | Decode second source register (rc) |
| hold_fetch_o | output | 1 | Freeze the fetch stage register |
| hold_decode_o | output | 1 | Freeze the decode stage register |
| ex_alu_o | output | 1 | Stage-3 ALU class flag (0 for a bubble) |
| ex_op_o | output | OP_W | Stage-3 opcode (0 for a bubble) |
| ex_dst_o | output | REG_W | Stage-3 destination register |

## Verification
The assertions assume that the pipeline around the unit honours the hold outputs. While hold is high, the decode inputs stay stable, so a stalled instruction is compared again and again with the same fields. They also assume that the decode inputs are known, and not X, after reset is released. The stimulus keeps to this rule. It drives each instruction away from the clock edge and holds it unchanged for as long as hold stays high. It presents the next instruction only after an edge at which hold was low, the same way a real frozen decode register would behave.

// File: rtl/alu_stall_pkg.sv
package alu_stall_pkg;
  // Opcode written into stage 3 when a bubble is injected.
  localparam int unsigned NOP_OPCODE = 0;
  // Default sizes shared by the unit and its checker.
  localparam int unsigned DEF_REG_W = 5;
  localparam int unsigned DEF_OP_W  = 5;
  // Number of stages behind decode whose results are not yet written back.
  localparam int unsigned DEF_DEPTH = 3;
endpackage

// File: rtl/stall_cmp.sv
module stall_cmp #(
  parameter int unsigned REG_W = 5
) (
  input  logic             prod_alu_i,
  input  logic [REG_W-1:0] prod_dst_i,
  input  logic             cons_alu_i,
  input  logic             cons_imm_i,
  input  logic [REG_W-1:0] cons_srca_i,
  input  logic [REG_W-1:0] cons_srcb_i,
  output logic             hit_o
);
  logic srca_eq;
  logic srcb_eq;

  always_comb begin
    srca_eq = (prod_dst_i == cons_srca_i);
    // the second source is only read when the consumer is not an immediate form
    srcb_eq = (prod_dst_i == cons_srcb_i) && !cons_imm_i;
    hit_o   = prod_alu_i && cons_alu_i && (srca_eq || srcb_eq);
  end
endmodule

// File: rtl/stall_track.sv
module stall_track #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned OP_W  = 5,
  parameter int unsigned DEPTH = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bubble_i,
  input  logic                   in_alu_i,
  input  logic [OP_W-1:0]        in_op_i,
  input  logic [REG_W-1:0]       in_dst_i,
  output logic [OP_W-1:0]        head_op_o,
  output logic [DEPTH-1:0]       alu_o,
  output logic [DEPTH*REG_W-1:0] dst_o
);
  import alu_stall_pkg::*;

  localparam logic [OP_W-1:0] BUBBLE_OP = OP_W'(NOP_OPCODE);

  logic             alu_q [DEPTH];
  logic [REG_W-1:0] dst_q [DEPTH];
  logic [OP_W-1:0]  op_q;

  // entry slot: takes the decode instruction or a bubble
  always_ff @(posedge clk) begin
    if (rst) begin
      alu_q[0] <= 1'b0;
      dst_q[0] <= '0;
      op_q     <= BUBBLE_OP;
    end else if (bubble_i) begin
      alu_q[0] <= 1'b0;
      dst_q[0] <= '0;
      op_q     <= BUBBLE_OP;
    end else begin
      alu_q[0] <= in_alu_i;
      dst_q[0] <= in_dst_i;
      op_q     <= in_op_i;
    end
  end

  // later slots always advance; no stall exists behind stage 3
  for (genvar k = 1; k < DEPTH; k++) begin : g_shift
    always_ff @(posedge clk) begin
      if (rst) begin
        alu_q[k] <= 1'b0;
        dst_q[k] <= '0;
      end else begin
        alu_q[k] <= alu_q[k-1];
        dst_q[k] <= dst_q[k-1];
      end
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_out
    assign alu_o[k]                 = alu_q[k];
    assign dst_o[k*REG_W +: REG_W]  = dst_q[k];
  end

  assign head_op_o = op_q;
endmodule

// File: rtl/alu_stall_unit.sv
module alu_stall_unit #(
  parameter int unsigned REG_W = alu_stall_pkg::DEF_REG_W,
  parameter int unsigned OP_W  = alu_stall_pkg::DEF_OP_W,
  parameter int unsigned DEPTH = alu_stall_pkg::DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_alu_i,
  input  logic             dec_imm_i,
  input  logic [OP_W-1:0]  dec_op_i,
  input  logic [REG_W-1:0] dec_dst_i,
  input  logic [REG_W-1:0] dec_srca_i,
  input  logic [REG_W-1:0] dec_srcb_i,
  output logic             hold_fetch_o,
  output logic             hold_decode_o,
  output logic             ex_alu_o,
  output logic [OP_W-1:0]  ex_op_o,
  output logic [REG_W-1:0] ex_dst_o
);
  localparam int unsigned DST_BITS = DEPTH * REG_W;

  logic [DEPTH-1:0]    trk_alu;
  logic [DST_BITS-1:0] trk_dst;
  logic [DEPTH-1:0]    stage_hit;
  logic                conflict;

  stall_track #(
    .REG_W(REG_W),
    .OP_W (OP_W),
    .DEPTH(DEPTH)
  ) track_i (
    .clk      (clk),
    .rst      (rst),
    .bubble_i (conflict),
    .in_alu_i (dec_alu_i),
    .in_op_i  (dec_op_i),
    .in_dst_i (dec_dst_i),
    .head_op_o(ex_op_o),
    .alu_o    (trk_alu),
    .dst_o    (trk_dst)
  );

  // one comparator per stage whose result is still in flight
  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    stall_cmp #(.REG_W(REG_W)) cmp_i (
      .prod_alu_i (trk_alu[k]),
      .prod_dst_i (trk_dst[k*REG_W +: REG_W]),
      .cons_alu_i (dec_alu_i),
      .cons_imm_i (dec_imm_i),
      .cons_srca_i(dec_srca_i),
      .cons_srcb_i(dec_srcb_i),
      .hit_o      (stage_hit[k])
    );
  end

  assign conflict      = |stage_hit;
  assign hold_fetch_o  = conflict;
  assign hold_decode_o = conflict;
  assign ex_alu_o      = trk_alu[0];
  assign ex_dst_o      = trk_dst[REG_W-1:0];
endmodule

// File: rtl/alu_stall_chk.sv
module alu_stall_chk #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned OP_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_alu_i,
  input logic             dec_imm_i,
  input logic [OP_W-1:0]  dec_op_i,
  input logic [REG_W-1:0] dec_srca_i,
  input logic [REG_W-1:0] dec_srcb_i,
  input logic             hold_fetch_o,
  input logic             hold_decode_o,
  input logic             ex_alu_o,
  input logic [OP_W-1:0]  ex_op_o,
  input logic [REG_W-1:0] ex_dst_o
);
  // R5
  hold_pair_chk: assert property (@(posedge clk) disable iff (rst)
    hold_fetch_o == hold_decode_o);

  // R6
  bubble_load_chk: assert property (@(posedge clk) disable iff (rst)
    hold_fetch_o |=> (ex_op_o == '0) && !ex_alu_o);

  // R6
  issue_load_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_fetch_o |=> (ex_op_o == $past(dec_op_i)) && (ex_alu_o == $past(dec_alu_i)));

  // R2
  srca_stage3_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_alu_i && ex_alu_o && (ex_dst_o == dec_srca_i)) |-> hold_fetch_o);

  // R3
  srcb_stage3_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_alu_i && !dec_imm_i && ex_alu_o && (ex_dst_o == dec_srcb_i)) |-> hold_fetch_o);

  // R8
  non_alu_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_alu_i |-> !hold_fetch_o);
endmodule

bind alu_stall_unit alu_stall_chk #(
  .REG_W(REG_W),
  .OP_W (OP_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .dec_alu_i    (dec_alu_i),
  .dec_imm_i    (dec_imm_i),
  .dec_op_i     (dec_op_i),
  .dec_srca_i   (dec_srca_i),
  .dec_srcb_i   (dec_srcb_i),
  .hold_fetch_o (hold_fetch_o),
  .hold_decode_o(hold_decode_o),
  .ex_alu_o     (ex_alu_o),
  .ex_op_o      (ex_op_o),
  .ex_dst_o     (ex_dst_o)
);

// File: tb/alu_stall_unit_tb.sv
module alu_stall_unit_tb_top;
  localparam int unsigned REG_W = 5;
  localparam int unsigned OP_W  = 5;

  typedef struct packed {
    logic       alu;
    logic       imm;
    logic [4:0] op;
    logic [4:0] dst;
    logic [4:0] sa;
    logic [4:0] sb;
    logic [3:0] stalls;
  } vec_t;

  // stream of decode instructions with the stall count each must see
  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 5'd1,  5'd1,  5'd2,  5'd3,  4'd0}, // empty pipe
    '{1'b1, 1'b0, 5'd2,  5'd4,  5'd1,  5'd5,  4'd3}, // R2 R7 rb right behind
    '{1'b1, 1'b0, 5'd3,  5'd6,  5'd7,  5'd4,  4'd3}, // R3 rc right behind
    '{1'b1, 1'b1, 5'd4,  5'd8,  5'd9,  5'd6,  4'd0}, // R3 rc masked by imm
    '{1'b1, 1'b0, 5'd5,  5'd10, 5'd11, 5'd12, 4'd0}, // independent
    '{1'b1, 1'b0, 5'd6,  5'd13, 5'd8,  5'd0,  4'd2}, // R4 producer two back
    '{1'b0, 1'b0, 5'd7,  5'd13, 5'd13, 5'd13, 4'd0}, // R8 non-ALU consumer
    '{1'b1, 1'b0, 5'd8,  5'd14, 5'd13, 5'd2,  4'd2}, // R8 non-ALU producer ignored
    '{1'b1, 1'b0, 5'd9,  5'd0,  5'd15, 5'd16, 4'd0}, // writes r0
    '{1'b1, 1'b0, 5'd10, 5'd17, 5'd0,  5'd18, 4'd3}, // R9 r0 compared
    '{1'b1, 1'b0, 5'd11, 5'd19, 5'd20, 5'd21, 4'd0},
    '{1'b1, 1'b0, 5'd12, 5'd24, 5'd25, 5'd26, 4'd0},
    '{1'b1, 1'b0, 5'd13, 5'd27, 5'd28, 5'd17, 4'd1}, // R4 producer three back
    '{1'b1, 1'b0, 5'd14, 5'd29, 5'd30, 5'd31, 4'd0}, // R4 producer gone
    '{1'b1, 1'b1, 5'd15, 5'd5,  5'd27, 5'd9,  4'd2}  // R2 rb still checked with imm
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             dec_alu = 1'b0;
  logic             dec_imm = 1'b0;
  logic [OP_W-1:0]  dec_op = '0;
  logic [REG_W-1:0] dec_dst = '0;
  logic [REG_W-1:0] dec_srca = '0;
  logic [REG_W-1:0] dec_srcb = '0;
  logic             hold_fetch, hold_decode, ex_alu;
  logic [OP_W-1:0]  ex_op;
  logic [REG_W-1:0] ex_dst;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  alu_stall_unit #(.REG_W(REG_W), .OP_W(OP_W), .DEPTH(3)) dut_i (
    .clk(clk), .rst(rst),
    .dec_alu_i(dec_alu), .dec_imm_i(dec_imm), .dec_op_i(dec_op),
    .dec_dst_i(dec_dst), .dec_srca_i(dec_srca), .dec_srcb_i(dec_srcb),
    .hold_fetch_o(hold_fetch), .hold_decode_o(hold_decode),
    .ex_alu_o(ex_alu), .ex_op_o(ex_op), .ex_dst_o(ex_dst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    dec_alu  = v.alu;
    dec_imm  = v.imm;
    dec_op   = v.op;
    dec_dst  = v.dst;
    dec_srca = v.sa;
    dec_srcb = v.sb;
  endtask

  // present one instruction at a falling edge, follow it until it issues
  task automatic issue(input vec_t v, input int idx);
    int n = 0;
    drive(v);
    #1;
    while (hold_fetch && n < 10) begin
      check(hold_decode == hold_fetch, "R5 hold pair", int'(hold_decode), int'(hold_fetch));
      @(negedge clk);
      check(ex_op == 0 && !ex_alu && ex_dst == 0, "R6 bubble", int'(ex_op), 0);
      n++;
      #1;
    end
    check(n == int'(v.stalls), $sformatf("R4/R7 stall count vec %0d", idx), n, int'(v.stalls));
    @(negedge clk);
    check(ex_op == v.op && ex_alu == v.alu && ex_dst == v.dst,
          $sformatf("R6 issue vec %0d", idx), int'(ex_op), int'(v.op));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset, even a decode on r0 sources sees no producer
    dec_alu = 1'b1; dec_srca = '0; dec_srcb = '0;
    #1;
    check(!hold_fetch && !hold_decode, "R1 no hold after reset", int'(hold_fetch), 0);
    check(ex_op == 0 && !ex_alu, "R1 stage3 empty", int'(ex_op), 0);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) issue(VEC[i], i);

    // R1: reset clears a live producer
    issue('{1'b1, 1'b0, 5'd20, 5'd3, 5'd1, 5'd1, 4'd0}, 100);
    rst = 1'b1;
    drive('{1'b1, 1'b0, 5'd21, 5'd4, 5'd3, 5'd3, 4'd0});
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!hold_fetch, "R1 reset drops producer", int'(hold_fetch), 0);
    check(ex_op == 0 && !ex_alu, "R1 reset stage3", int'(ex_op), 0);
    @(negedge clk);

    // R8: non-ALU stage3 entry with matching destination does not hold
    issue('{1'b0, 1'b0, 5'd7, 5'd9, 5'd0, 5'd0, 4'd0}, 101);
    drive('{1'b1, 1'b0, 5'd22, 5'd1, 5'd9, 5'd9, 4'd0});
    #1;
    check(!hold_fetch, "R8 non-ALU producer", int'(hold_fetch), 0);
    @(negedge clk);

    finish_run();
  end
endmodule